// File: doc/BRIEF.md
# SDRAM Power-Up, Refresh and Self-Refresh Command Sequencer

This block owns the command pins of one rank of single-data-rate SDRAM whenever the memory is not being read or written. After reset it holds the bus quiet for a programmable power-up wait. It then brings the device up: it closes every bank, runs a fixed burst of auto refresh cycles and loads the mode register with a parameter value. When that is done it raises `ready`, and the access logic may then use the bus.

During normal operation an internal interval timer asks for one auto refresh per refresh period. The access side can hold refresh off with `ref_defer` while it is mid-transfer. If a request is still waiting when the next period ends, the block marks the interval as missed. It then serves the backlog with two auto refresh commands, issued back to back. A level request, `sleep_req`, puts the device into self refresh by lowering the clock enable. Dropping the request raises the clock enable again. The exit counts as taken on the second rising edge after that, and `ready` returns only once a full row-cycle time has passed.

All timing values are counted in clock cycles and set by parameters, so the command stream can be checked by counting cycles.

Top module: `sdram_cmd_seq`

## Requirements
- R1: For the first T_PWR cycles after reset is released, the block drives only NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1) with cke high and ready low.
- R2: The first non-NOP command is precharge-all (0,0,1,0 with addr bit AP_BIT = 10 high), issued exactly T_PWR cycles after reset release.
- R3: Exactly T_RP cycles after the precharge, the block issues INIT_REFS (default 8) auto refresh commands (0,0,0,1) spaced T_RC apart. Exactly T_RC cycles after the last one it issues mode register set (0,0,0,0) with addr = MODE_WORD and ba = 0.
- R4: After every auto refresh, the bus carries only NOP for the following T_RC-1 cycles.
- R5: ready first rises exactly T_MRD cycles after the mode register set command, and never earlier.
- R6: While operating normally, the block issues one auto refresh per T_REFI-cycle interval. The first one comes T_REFI+1 cycles after ready rises. ready is low from each refresh command until its T_RC window ends, and no command other than NOP is issued while ready is high.
- R7: While ref_defer is high, a due refresh waits. If a pending request is not served before the next interval ends, the next service is two auto refresh commands exactly T_RC apart. After that, service is single again, so the next gap is more than T_RC.
- R8: sleep_req high in the ready state causes a self-refresh entry command: the auto refresh encoding with cke low. From then on cke stays low, only NOP is driven, sr_active is high, ready is low and no refresh is issued.
- R9: After sleep_req falls, cke rises in the next cycle. The exit counts as taken on the second rising edge after that. ready returns exactly T_RC+1 cycles after cke first reads high, and only NOP is driven in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every command is registered by the memory on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; release starts the power-up wait |
| ref_defer | input | 1 | Access logic is mid-transfer; a due refresh must wait |
| sleep_req | input | 1 | Level request: high to enter self refresh, low to leave it |
| ready | output | 1 | Memory is initialized and idle; the access logic may use the bus |
| sr_active | output | 1 | Self refresh entered and still held |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address, zero for every command issued here |
| addr | output | ADDR_W | Address bus: all-banks bit for precharge, mode word for mode register set |

## Verification
An undisturbed power-up is checked for exact gaps between every initialization command. A wrong refresh count, a short row-cycle wait or an early ready each shifts a gap or the command order. Free-running refresh with no deferral sets the periodic timing. A deferral that covers more than two intervals must produce a pair of refreshes exactly T_RC apart, followed by a single one; this separates the missed-interval recovery from plain catch-up. Finally, holding and then dropping sleep_req checks that the bus stays silent with cke low while asleep, and that ready returns on the exact cycle set by the second-edge exit rule plus T_RC.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   typedef enum logic [3:0] {
      S_PWR, S_PALL, S_WRP, S_IREF, S_IWRC, S_MRS, S_WMRD,
      S_IDLE, S_REF, S_WRC, S_SRE, S_SRH, S_SRX, S_SRRC
   } seq_state_t;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_t;

   localparam cmd_t CMD_NOP = 4'b0111;
   localparam cmd_t CMD_PRE = 4'b0010;
   localparam cmd_t CMD_REF = 4'b0001;
   localparam cmd_t CMD_MRS = 4'b0000;

endpackage

// File: rtl/sdram_dly_cnt.sv
// Down counter for one timing rule. 'last' is high one cycle before the
// next command may go out, so the next-state logic lands exactly on time.
module sdram_dly_cnt #(
   parameter int unsigned CYC   = 4,
   parameter bit          ARMED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic last
);
   localparam int unsigned W = $clog2(CYC + 1);
   localparam logic [W-1:0] RST_V = ARMED ? W'(CYC) : '0;

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= RST_V;
      else if (start)       cnt <= W'(CYC - 1);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign last = (cnt == W'(1));
endmodule

// File: rtl/sdram_refi_timer.sv
// Interval timer: raises a refresh request once per period and flags a
// missed interval when a request is still waiting at the next period end.
module sdram_refi_timer #(
   parameter int unsigned T_REFI = 780
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ack,
   output logic req,
   output logic ovf
);
   localparam int unsigned W = $clog2(T_REFI);

   logic [W-1:0] cnt;
   logic         tick;

   assign tick = en && (cnt == W'(T_REFI - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         req <= 1'b0;
         ovf <= 1'b0;
      end else if (!en) begin
         cnt <= '0;
         req <= 1'b0;
         ovf <= 1'b0;
      end else begin
         cnt <= tick ? '0 : cnt + 1'b1;
         if (tick) begin
            req <= 1'b1;
            ovf <= ack ? 1'b0 : (ovf | req);
         end else if (ack) begin
            req <= 1'b0;
            ovf <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned BA_W      = 2,
   parameter int unsigned AP_BIT    = 10,
   parameter int unsigned T_PWR     = 10000,
   parameter int unsigned T_RP      = 3,
   parameter int unsigned T_RC      = 9,
   parameter int unsigned T_MRD     = 2,
   parameter int unsigned T_REFI    = 780,
   parameter int unsigned INIT_REFS = 8,
   parameter logic [ADDR_W-1:0] MODE_WORD = 'h032,
   parameter bit          OUT_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_defer,
   input  logic              sleep_req,
   output logic              ready,
   output logic              sr_active,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr
);
   import sdram_seq_pkg::*;

   localparam int unsigned RL_W = $clog2(INIT_REFS + 1);

   // elaboration-time parameter checks
   if (T_PWR < 2 || T_RP < 2 || T_RC < 2 || T_MRD < 2) begin : g_bad_timing
      $error("sdram_cmd_seq: every wait parameter must be at least 2 cycles");
   end
   if (T_REFI < T_RC * 2 + 4) begin : g_bad_refi
      $error("sdram_cmd_seq: T_REFI must exceed two row cycles plus margin");
   end
   if (INIT_REFS < 2) begin : g_bad_refs
      $error("sdram_cmd_seq: INIT_REFS must be at least 2");
   end
   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("sdram_cmd_seq: AP_BIT outside the address bus");
   end

   seq_state_t st, nxt;
   logic [RL_W-1:0] refs_left;
   logic            wake_half;
   logic            pwr_last, rp_last, rc_last, mrd_last;
   logic            rp_go, rc_go, mrd_go;
   logic            ref_req, ref_ovf, ref_ack, tmr_en;

   sdram_dly_cnt #(.CYC(T_PWR), .ARMED(1'b1)) u_pwr (
      .clk(clk), .rst_n(rst_n), .start(1'b0), .last(pwr_last));
   sdram_dly_cnt #(.CYC(T_RP)) u_rp (
      .clk(clk), .rst_n(rst_n), .start(rp_go), .last(rp_last));
   sdram_dly_cnt #(.CYC(T_RC)) u_rc (
      .clk(clk), .rst_n(rst_n), .start(rc_go), .last(rc_last));
   sdram_dly_cnt #(.CYC(T_MRD)) u_mrd (
      .clk(clk), .rst_n(rst_n), .start(mrd_go), .last(mrd_last));

   assign tmr_en = (st == S_IDLE) || (st == S_REF) || (st == S_WRC);

   sdram_refi_timer #(.T_REFI(T_REFI)) u_refi (
      .clk(clk), .rst_n(rst_n), .en(tmr_en), .ack(ref_ack),
      .req(ref_req), .ovf(ref_ovf));

   // next state and timer starts
   always_comb begin
      nxt     = st;
      rp_go   = 1'b0;
      rc_go   = 1'b0;
      mrd_go  = 1'b0;
      ref_ack = 1'b0;
      case (st)
         S_PWR:  if (pwr_last) nxt = S_PALL;
         S_PALL: begin rp_go = 1'b1; nxt = S_WRP; end
         S_WRP:  if (rp_last) nxt = S_IREF;
         S_IREF: begin rc_go = 1'b1; nxt = S_IWRC; end
         S_IWRC: if (rc_last) nxt = (refs_left == '0) ? S_MRS : S_IREF;
         S_MRS:  begin mrd_go = 1'b1; nxt = S_WMRD; end
         S_WMRD: if (mrd_last) nxt = S_IDLE;
         S_IDLE: begin
            if (ref_req && !ref_defer) begin
               ref_ack = 1'b1;
               nxt     = S_REF;
            end else if (sleep_req) begin
               nxt = S_SRE;
            end
         end
         S_REF:  begin rc_go = 1'b1; nxt = S_WRC; end
         S_WRC:  if (rc_last) nxt = (refs_left == '0) ? S_IDLE : S_REF;
         S_SRE:  nxt = S_SRH;
         S_SRH:  if (!sleep_req) nxt = S_SRX;
         S_SRX:  if (wake_half) begin rc_go = 1'b1; nxt = S_SRRC; end
         S_SRRC: if (rc_last) nxt = S_IDLE;
         default: nxt = S_PWR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_PWR;
         refs_left <= RL_W'(INIT_REFS);
         wake_half <= 1'b0;
      end else begin
         st        <= nxt;
         wake_half <= (st == S_SRX) && !wake_half;
         if (ref_ack)
            refs_left <= ref_ovf ? RL_W'(2) : RL_W'(1);
         else if (st == S_IREF || st == S_REF)
            refs_left <= refs_left - 1'b1;
      end
   end

   // command decode from state
   cmd_t              cmd_c;
   logic              cke_c, rdy_c, sra_c;
   logic [ADDR_W-1:0] addr_c;

   always_comb begin
      cmd_c  = CMD_NOP;
      cke_c  = 1'b1;
      addr_c = '0;
      rdy_c  = (st == S_IDLE);
      sra_c  = (st == S_SRE) || (st == S_SRH);
      case (st)
         S_PALL: begin cmd_c = CMD_PRE; addr_c[AP_BIT] = 1'b1; end
         S_IREF, S_REF: cmd_c = CMD_REF;
         S_MRS:  begin cmd_c = CMD_MRS; addr_c = MODE_WORD; end
         S_SRE:  begin cmd_c = CMD_REF; cke_c = 1'b0; end
         S_SRH:  cke_c = 1'b0;
         default: ;
      endcase
   end

   assign ba = '0;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
            cke       <= 1'b1;
            addr      <= '0;
            ready     <= 1'b0;
            sr_active <= 1'b0;
         end else begin
            {cs_n, ras_n, cas_n, we_n} <= cmd_c;
            cke       <= cke_c;
            addr      <= addr_c;
            ready     <= rdy_c;
            sr_active <= sra_c;
         end
      end
   end else begin : g_out_comb
      assign {cs_n, ras_n, cas_n, we_n} = cmd_c;
      assign cke       = cke_c;
      assign addr      = addr_c;
      assign ready     = rdy_c;
      assign sr_active = sra_c;
   end
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned BA_W      = 2,
   parameter int unsigned AP_BIT    = 10,
   parameter int unsigned T_PWR     = 10000,
   parameter int unsigned T_RC      = 9,
   parameter int unsigned T_MRD     = 2,
   parameter int unsigned INIT_REFS = 8,
   parameter logic [ADDR_W-1:0] MODE_WORD = 'h032
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready,
   input logic              sr_active,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BA_W-1:0]   ba,
   input logic [ADDR_W-1:0] addr
);
   logic is_nop, is_cmd, is_pre, is_ref, is_mrs;
   assign is_nop = !cs_n && ras_n && cas_n && we_n;
   assign is_cmd = !cs_n && !(ras_n && cas_n && we_n);
   assign is_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
   assign is_ref = ({cs_n, ras_n, cas_n, we_n} == 4'b0001);
   assign is_mrs = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);

   int unsigned pw_cnt, init_refs, mrd_age, rc_age, sx_age;
   logic first_seen, mrs_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pw_cnt     <= 0;
         init_refs  <= 0;
         mrd_age    <= 0;
         rc_age     <= 0;
         sx_age     <= T_RC + 1;
         first_seen <= 1'b0;
         mrs_seen   <= 1'b0;
      end else begin
         if (pw_cnt < T_PWR) pw_cnt <= pw_cnt + 1;
         if (is_cmd) first_seen <= 1'b1;
         if (is_mrs) mrs_seen <= 1'b1;
         if (is_ref && !mrs_seen) init_refs <= init_refs + 1;
         if (is_mrs) mrd_age <= 1;
         else if (mrd_age != 0 && mrd_age < T_MRD) mrd_age <= mrd_age + 1;
         if (is_ref) rc_age <= 1;
         else if (rc_age != 0 && rc_age < T_RC) rc_age <= rc_age + 1;
         if (!cke) sx_age <= 0;
         else if (sx_age < T_RC + 1) sx_age <= sx_age + 1;
      end
   end

   a_r1_quiet_powerup: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_cnt < T_PWR) |-> (is_nop && cke && !ready));

   a_r2_first_is_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmd && !first_seen) |-> (is_pre && addr[AP_BIT]));

   a_r3_refs_before_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mrs && !mrs_seen) |-> (init_refs == INIT_REFS && addr == MODE_WORD && ba == '0));

   a_r4_nop_inside_trc: assert property (@(posedge clk) disable iff (!rst_n)
      (rc_age != 0 && rc_age < T_RC) |-> !is_cmd);

   a_r5_ready_after_mrd: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mrs_seen && mrd_age >= T_MRD));

   a_r6_ready_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (is_nop && cke && !sr_active));

   a_r8_cke_falls_with_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke) |-> is_ref);

   a_r8_asleep_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke && $past(!cke)) |-> (is_nop && sr_active && !ready));

   a_r9_exit_waits_trc: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (sx_age > T_RC));
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
   .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT), .T_PWR(T_PWR),
   .T_RC(T_RC), .T_MRD(T_MRD), .INIT_REFS(INIT_REFS), .MODE_WORD(MODE_WORD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ready(ready), .sr_active(sr_active),
   .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
   .ba(ba), .addr(addr)
);

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW     = 13;
   localparam int T_PWR  = 40;
   localparam int T_RP   = 3;
   localparam int T_RC   = 6;
   localparam int T_MRD  = 2;
   localparam int T_REFI = 60;
   localparam int NREF   = 8;
   localparam logic [AW-1:0] MODE = 13'h032;
   localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010,
                          C_REF = 4'b0001, C_MRS = 4'b0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_defer = 1'b0;
   logic sleep_req = 1'b0;
   logic ready, sr_active, cke, cs_n, ras_n, cas_n, we_n;
   logic [1:0]    ba;
   logic [AW-1:0] addr;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sdram_cmd_seq #(
      .ADDR_W(AW), .BA_W(2), .AP_BIT(10), .T_PWR(T_PWR), .T_RP(T_RP),
      .T_RC(T_RC), .T_MRD(T_MRD), .T_REFI(T_REFI), .INIT_REFS(NREF),
      .MODE_WORD(MODE), .OUT_REG(1'b0)
   ) u_sdram_cmd_seq (
      .clk(clk), .rst_n(rst_n), .ref_defer(ref_defer), .sleep_req(sleep_req),
      .ready(ready), .sr_active(sr_active), .cke(cke), .cs_n(cs_n),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
   );

   typedef struct {
      logic [3:0] code;
      logic       cke_v;
      int         lo;
      int         hi;
      int         amode;   // 0 none, 1 all-banks bit, 2 full word
      bit         want_rdy_low;
      string      tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int fails  = 0;
   int pe = 0;          // rising edges since reset release
   int last_c = 0;      // cycle of the last command seen

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic push(input logic [3:0] code, input logic ck, input int lo,
                       input int hi, input int am, input bit rl, input string tag);
      exp_t e;
      e.code = code; e.cke_v = ck; e.lo = lo; e.hi = hi;
      e.amode = am; e.want_rdy_low = rl; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
   endtask

   task automatic wait_cycle(input int c);
      while (pe < c) @(negedge clk);
   endtask

   always @(posedge clk) if (rst_n) pe <= pe + 1;

   // monitor: pops expectations as commands appear on the bus
   always @(negedge clk) begin
      if (rst_n && !cs_n && !(ras_n && cas_n && we_n)) begin
         if (q.size() == 0) begin
            check(1'b0, "R4/R8 unexpected command", int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
         end else begin
            exp_t e;
            e = q.pop_front();
            check({cs_n, ras_n, cas_n, we_n} == e.code, {e.tag, " code"},
                  int'({cs_n, ras_n, cas_n, we_n}), int'(e.code));
            check((pe - last_c) >= e.lo && (pe - last_c) <= e.hi, {e.tag, " gap"},
                  pe - last_c, e.lo);
            check(cke == e.cke_v, {e.tag, " cke"}, int'(cke), int'(e.cke_v));
            if (e.amode == 1) check(addr[10] == 1'b1, {e.tag, " all-banks bit"}, int'(addr[10]), 1);
            if (e.amode == 2) check(addr == MODE && ba == 2'b00, {e.tag, " mode word"}, int'(addr), int'(MODE));
            if (e.want_rdy_low) check(ready == 1'b0, {e.tag, " ready low"}, int'(ready), 0);
            last_c = pe;
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin : driver
      int mrs_c, rel_c, ck_c;
      bit bad;
      // reset state (R1)
      repeat (4) @(negedge clk);
      check(ready == 1'b0, "R1 reset ready", int'(ready), 0);
      check(cke == 1'b1, "R1 reset cke", int'(cke), 1);
      check({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1 reset bus NOP",
            int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
      check(sr_active == 1'b0, "R8 reset sr_active", int'(sr_active), 0);

      // initialization sequence expectations
      push(C_PRE, 1'b1, T_PWR, T_PWR, 1, 1'b1, "R2 precharge all");
      push(C_REF, 1'b1, T_RP, T_RP, 0, 1'b1, "R3 first init refresh");
      for (int i = 1; i < NREF; i++)
         push(C_REF, 1'b1, T_RC, T_RC, 0, 1'b1, "R3 R4 init refresh spacing");
      push(C_MRS, 1'b1, T_RC, T_RC, 2, 1'b1, "R3 mode register set");
      rst_n = 1'b1;

      wait_cycle(T_PWR / 2);
      check(cke && !ready && {cs_n, ras_n, cas_n, we_n} == C_NOP, "R1 mid power-up quiet",
            int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
      drain();
      mrs_c = last_c;
      wait_cycle(mrs_c + T_MRD - 1);
      check(ready == 1'b0, "R5 ready before tMRD", int'(ready), 0);
      wait_cycle(mrs_c + T_MRD);
      check(ready == 1'b1, "R5 ready at tMRD", int'(ready), 1);

      // periodic refresh, undisturbed
      push(C_REF, 1'b1, T_MRD + T_REFI, T_MRD + T_REFI + 2, 0, 1'b1, "R6 periodic refresh");
      drain();
      rel_c = last_c;
      wait_cycle(rel_c + T_RC - 1);
      check(ready == 1'b0, "R6 ready low inside tRC", int'(ready), 0);
      wait_cycle(rel_c + T_RC);
      check(ready == 1'b1, "R6 ready back after tRC", int'(ready), 1);

      // deferral across two intervals: missed-interval recovery
      #1 ref_defer = 1'b1;
      repeat (2 * T_REFI + 5) @(negedge clk);
      check(ready == 1'b1, "R7 ready while deferred", int'(ready), 1);
      push(C_REF, 1'b1, T_RC, 4 * T_REFI, 0, 1'b1, "R7 recovery first");
      push(C_REF, 1'b1, T_RC, T_RC, 0, 1'b1, "R7 recovery second back-to-back");
      push(C_REF, 1'b1, T_RC + 1, T_REFI + 2, 0, 1'b1, "R7 single service afterwards");
      #1 ref_defer = 1'b0;
      drain();

      // self refresh entry
      #1 sleep_req = 1'b1;
      push(C_REF, 1'b0, T_RC + 1, T_RC + 1, 0, 1'b1, "R8 self refresh entry");
      drain();
      bad = 1'b0;
      for (int i = 0; i < 3 * T_REFI; i++) begin
         @(negedge clk);
         if (cke || !sr_active || ready) bad = 1'b1;
      end
      check(!bad, "R8 held asleep with cke low", int'(bad), 0);

      // self refresh exit
      @(negedge clk);
      rel_c = pe;
      #1 sleep_req = 1'b0;
      while (!cke) @(negedge clk);
      ck_c = pe;
      check(ck_c == rel_c + 1, "R9 cke rises next cycle", ck_c - rel_c, 1);
      check(sr_active == 1'b0, "R9 sr_active cleared", int'(sr_active), 0);
      wait_cycle(ck_c + T_RC);
      check(ready == 1'b0, "R9 ready still low before exit tRC", int'(ready), 0);
      wait_cycle(ck_c + T_RC + 1);
      check(ready == 1'b1, "R9 ready after exit tRC", int'(ready), 1);

      repeat (T_REFI / 2) @(negedge clk);
      check(q.size() == 0, "R6 all expected commands seen", q.size(), 0);
      summary();
      $finish;
   end
endmodule